// File: doc/BRIEF.md
# Peripheral Clock Gate Controller

This block sits between a simple register bus and a row of peripherals. For each peripheral it drives a gated clock and an active-low reset. It also filters that peripheral's bus select and read data. Software controls the peripherals through two registers. A one in the clock-enable word keeps a peripheral's clock running, and a zero stops it. A one in the reset word holds the peripheral in reset.

A change to the clock-enable word does not act at once. Each bit launches a level request into the peripheral clock domain through two flops. The gate enable is latched while the peripheral clock is low. The state that was applied then returns through two more flops. The readable clock-enable bit follows only that returned state. Software therefore polls until the value it reads agrees with the value it wrote, and only then touches the peripheral.

Some bits cannot change. Bits of absent peripherals ignore writes and read zero. Bits whose bus clock is flagged as off ignore writes and keep the value they hold. While a peripheral's clock is stopped, or while a change to it is still in flight, its bus select is suppressed and its read data is replaced by a fixed word. The reset can be asserted and released whether or not the peripheral's clock is gated.

Top module: `periph_clk_gate`

## Requirements
- R1: The clock-enable word is at address 0 and the reset word is at address 1. Bit i of each word belongs to peripheral i. After reset the clock-enable word reads the implemented-peripheral mask (default 0xBF), the reset word reads 0, and each implemented peripheral's reset output goes high within 8 peripheral clock cycles.
- R2: Writing 0 to clock-enable bit i stops `pclk_gated_o[i]` and drives `gate_en_o[i]` low. Writing 1 makes it toggle again. Other peripherals are unaffected.
- R3: One bus cycle after a clock-enable write, the readback still shows the old value. It shows the written value within 20 bus cycles, once the gate change has been applied.
- R4: A clock-enable write made while a change to that bit is still in flight is held and applied after that change completes. Of several held writes, the last one wins.
- R5: Writing 1 to reset bit i drives `prst_n_o[i]` low by the next bus cycle, even while the peripheral's clock is gated. Writing 0 releases it only on peripheral clock edges: it is still low one bus cycle later and high within 8 bus cycles.
- R6: Bits of absent peripherals (default: bit 6) ignore writes to both words and read 0. The gated clock and the reset output of such a peripheral stay low.
- R7: While `bus_off_i[i]` is 1, writes to bit i of both words are ignored and the bit keeps its value.
- R8: `psel_o[i]` follows `psel_i[i]` only while the readback of bit i is 1 and no change to bit i is in flight. When the selected peripheral is blocked, `prdata_o` returns the fixed value 0. Otherwise it passes `prdata_i` through.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pclk | input | 1 | Free-running peripheral source clock |
| bus_sel | input | 1 | Register access strobe |
| bus_we | input | 1 | Write when 1, read when 0 |
| bus_addr | input | 2 | Word select: 0 clock enable, 1 reset |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data of the addressed word |
| bus_off_i | input | N | Per-peripheral bus clock off flag |
| pclk_gated_o | output | N | Gated clock per peripheral |
| gate_en_o | output | N | Latched gate enable per peripheral |
| prst_n_o | output | N | Active-low reset per peripheral |
| psel_i | input | N | Peripheral select from the system bus |
| prdata_i | input | 32 | Read data from the selected peripheral |
| psel_o | output | N | Filtered peripheral select |
| prdata_o | output | 32 | Filtered read data |

## Verification
Access blocking and the launch of a gate change can occur in the same cycle. The bench holds `psel_i` high on a running peripheral and writes a zero to its clock-enable bit. On the next bus cycle it checks two things together: `psel_o` must already be low, and the readback must still report the clock as on. A second overlap happens when a returning acknowledge meets a new write to the same bit. The bench issues writes on back-to-back cycles, so that the held value is released in the cycle the acknowledge lands. The final gate state and readback are then compared with the last value written.

// File: rtl/pcg_pkg.sv
package pcg_pkg;
  localparam int REG_W = 32;

  typedef enum logic [1:0] {
    SEL_CLKEN = 2'd0,
    SEL_RESET = 2'd1
  } reg_sel_e;
endpackage

// File: rtl/pcg_regs.sv
// Bus-side state: clock-enable targets, held writes and reset bits.
module pcg_regs #(
  parameter int            N         = 8,
  parameter logic [31:0]   CE_RESET  = 32'h0000_00BF
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_ce,
  input  logic         wr_rst,
  input  logic [N-1:0] wdata,
  input  logic [N-1:0] wr_mask,
  input  logic [N-1:0] ce_rb,
  output logic [N-1:0] ce_tgt,
  output logic [N-1:0] rst_q,
  output logic [N-1:0] running
);
  localparam logic [N-1:0] TGT_INIT = CE_RESET[N-1:0];

  logic [N-1:0] tgt_d, hold_q, hold_d, hval_q, hval_d, rst_d, pend;

  always_comb begin
    tgt_d  = ce_tgt;
    hold_d = hold_q;
    hval_d = hval_q;
    rst_d  = rst_q;
    for (int i = 0; i < N; i++) begin
      pend[i] = ce_tgt[i] ^ ce_rb[i];
      if (wr_ce && wr_mask[i]) begin
        if (pend[i] || hold_q[i]) begin
          hval_d[i] = wdata[i];
          hold_d[i] = 1'b1;
        end else begin
          tgt_d[i] = wdata[i];
        end
      end else if (hold_q[i] && !pend[i] && wr_mask[i]) begin
        tgt_d[i]  = hval_q[i];
        hold_d[i] = 1'b0;
      end
      if (wr_rst && wr_mask[i]) begin
        rst_d[i] = wdata[i];
      end
    end
  end

  assign running = ce_rb & ~pend;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ce_tgt <= TGT_INIT;
      hold_q <= '0;
      hval_q <= '0;
      rst_q  <= '0;
    end else begin
      ce_tgt <= tgt_d;
      hold_q <= hold_d;
      hval_q <= hval_d;
      rst_q  <= rst_d;
    end
  end
endmodule

// File: rtl/pcg_lane.sv
// One peripheral: request sync, glitch-free gate, acknowledge sync, reset sync.
module pcg_lane (
  input  logic clk,
  input  logic rst_n,
  input  logic pclk,
  input  logic prst_sys_n,
  input  logic tgt,
  input  logic rst_req,
  output logic rb,
  output logic gclk,
  output logic gate_en,
  output logic prst_n
);
  logic [1:0] req_q;
  logic       en_lat;
  logic       ack_q;
  logic [1:0] back_q;
  logic [1:0] rs_q;
  logic       arst_n;

  // request into the peripheral clock domain
  always_ff @(posedge pclk or negedge prst_sys_n) begin
    if (!prst_sys_n) req_q <= 2'b11;
    else             req_q <= {req_q[0], tgt};
  end

  // enable may only move while the source clock is low
  always_latch begin
    if (!prst_sys_n)  en_lat <= 1'b1;
    else if (!pclk)   en_lat <= req_q[1];
  end

  assign gclk    = pclk & en_lat;
  assign gate_en = en_lat;

  // state actually applied, sampled after the low phase
  always_ff @(posedge pclk or negedge prst_sys_n) begin
    if (!prst_sys_n) ack_q <= 1'b1;
    else             ack_q <= en_lat;
  end

  // acknowledge back into the bus domain
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) back_q <= 2'b11;
    else        back_q <= {back_q[0], ack_q};
  end
  assign rb = back_q[1];

  // peripheral reset: asynchronous entry, release on pclk
  assign arst_n = rst_n & ~rst_req;
  always_ff @(posedge pclk or negedge arst_n) begin
    if (!arst_n) rs_q <= 2'b00;
    else         rs_q <= {rs_q[0], 1'b1};
  end
  assign prst_n = rs_q[1];
endmodule

// File: rtl/periph_clk_gate.sv
module periph_clk_gate
  import pcg_pkg::*;
#(
  parameter int          N           = 8,
  parameter logic [31:0] IMPL_MASK   = 32'h0000_00BF,
  parameter logic [31:0] BLOCK_RDATA = 32'h0000_0000
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pclk,
  input  logic             bus_sel,
  input  logic             bus_we,
  input  logic [1:0]       bus_addr,
  input  logic [REG_W-1:0] bus_wdata,
  output logic [REG_W-1:0] bus_rdata,
  input  logic [N-1:0]     bus_off_i,
  output logic [N-1:0]     pclk_gated_o,
  output logic [N-1:0]     gate_en_o,
  output logic [N-1:0]     prst_n_o,
  input  logic [N-1:0]     psel_i,
  input  logic [REG_W-1:0] prdata_i,
  output logic [N-1:0]     psel_o,
  output logic [REG_W-1:0] prdata_o
);
  localparam logic [N-1:0] IMPL = IMPL_MASK[N-1:0];

  logic             wr_ce, wr_rst;
  logic [N-1:0]     ce_rb, ce_tgt, rst_q, running;
  logic [1:0]       prs_q;
  logic             prst_sys_n;
  logic             blocked;
  logic [REG_W-1:0] wd_unused;
  logic [N-1:0]     tgt_unused;

  assign wd_unused  = bus_wdata;
  assign tgt_unused = ce_tgt & ~IMPL;

  assign wr_ce  = bus_sel & bus_we & (bus_addr == SEL_CLKEN);
  assign wr_rst = bus_sel & bus_we & (bus_addr == SEL_RESET);

  // global reset into the peripheral clock domain
  always_ff @(posedge pclk or negedge rst_n) begin
    if (!rst_n) prs_q <= 2'b00;
    else        prs_q <= {prs_q[0], 1'b1};
  end
  assign prst_sys_n = prs_q[1];

  pcg_regs #(.N(N), .CE_RESET(IMPL_MASK)) u_regs (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_ce   (wr_ce),
    .wr_rst  (wr_rst),
    .wdata   (bus_wdata[N-1:0]),
    .wr_mask (IMPL & ~bus_off_i),
    .ce_rb   (ce_rb),
    .ce_tgt  (ce_tgt),
    .rst_q   (rst_q),
    .running (running)
  );

  for (genvar i = 0; i < N; i++) begin : g_lane
    if (IMPL[i]) begin : g_on
      pcg_lane u_lane (
        .clk        (clk),
        .rst_n      (rst_n),
        .pclk       (pclk),
        .prst_sys_n (prst_sys_n),
        .tgt        (ce_tgt[i]),
        .rst_req    (rst_q[i]),
        .rb         (ce_rb[i]),
        .gclk       (pclk_gated_o[i]),
        .gate_en    (gate_en_o[i]),
        .prst_n     (prst_n_o[i])
      );
    end else begin : g_off
      assign ce_rb[i]        = 1'b0;
      assign pclk_gated_o[i] = 1'b0;
      assign gate_en_o[i]    = 1'b0;
      assign prst_n_o[i]     = 1'b0;
    end
  end

  always_comb begin
    bus_rdata = '0;
    case (bus_addr)
      SEL_CLKEN: bus_rdata[N-1:0] = ce_rb;
      SEL_RESET: bus_rdata[N-1:0] = rst_q;
      default:   bus_rdata = '0;
    endcase
  end

  assign psel_o   = psel_i & running;
  assign blocked  = |(psel_i & ~running);
  assign prdata_o = blocked ? BLOCK_RDATA : prdata_i;
endmodule

// File: rtl/pcg_chk.sv
module pcg_chk #(
  parameter int          N         = 8,
  parameter logic [31:0] IMPL_MASK = 32'h0000_00BF
) (
  input logic         clk,
  input logic         rst_n,
  input logic [N-1:0] ce_rb,
  input logic [N-1:0] ce_tgt,
  input logic [N-1:0] rst_q,
  input logic [N-1:0] bus_off_i,
  input logic [N-1:0] psel_o,
  input logic [N-1:0] prst_n_o
);
  localparam logic [N-1:0] IMPL = IMPL_MASK[N-1:0];

  // R3
  rb_lands_on_target_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((ce_rb ^ $past(ce_rb)) & (ce_rb ^ ce_tgt)) == '0);

  // R6
  absent_reads_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((ce_rb | rst_q) & ~IMPL) == '0);

  // R7
  bus_off_reset_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((rst_q ^ $past(rst_q)) & $past(bus_off_i)) == '0);

  // R7
  bus_off_clken_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((ce_tgt ^ $past(ce_tgt)) & $past(bus_off_i)) == '0);

  // R8
  gated_select_blocked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (psel_o & ~ce_rb) == '0);

  // R5
  reset_applied_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rst_q & prst_n_o) == '0);
endmodule

bind periph_clk_gate pcg_chk #(.N(N), .IMPL_MASK(IMPL_MASK)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .ce_rb     (ce_rb),
  .ce_tgt    (ce_tgt),
  .rst_q     (rst_q),
  .bus_off_i (bus_off_i),
  .psel_o    (psel_o),
  .prst_n_o  (prst_n_o)
);

// File: tb/sim_periph_clk_gate.sv
`timescale 1ns/1ps
module sim_periph_clk_gate;
  localparam int N = 8;
  localparam logic [31:0] IMPL = 32'h0000_00BF;

  logic        clk = 1'b0, pclk = 1'b0, rst_n = 1'b0;
  logic        bus_sel = 1'b0, bus_we = 1'b0;
  logic [1:0]  bus_addr = 2'd0;
  logic [31:0] bus_wdata = '0, bus_rdata, prdata_i = '0, prdata_o;
  logic [N-1:0] bus_off_i = '0, psel_i = '0;
  logic [N-1:0] pclk_gated_o, gate_en_o, prst_n_o, psel_o;

  int checks = 0, errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;    // 125 MHz
  always #5 pclk = ~pclk;

  periph_clk_gate #(.N(N), .IMPL_MASK(IMPL)) u0 (
    .clk(clk), .rst_n(rst_n), .pclk(pclk), .bus_sel(bus_sel), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .bus_off_i(bus_off_i), .pclk_gated_o(pclk_gated_o), .gate_en_o(gate_en_o),
    .prst_n_o(prst_n_o), .psel_i(psel_i), .prdata_i(prdata_i), .psel_o(psel_o),
    .prdata_o(prdata_o)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic bus_wr(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 1'b0; bus_we = 1'b0;
    #1;
  endtask

  task automatic bus_rd(input logic [1:0] a, output logic [31:0] d);
    bus_addr = a;
    #1 d = bus_rdata;
  endtask

  // poll the clock-enable word until it equals exp, up to lim bus cycles
  task automatic wait_ce(input logic [31:0] exp, input int lim, output logic [31:0] got);
    for (int k = 0; k < lim; k++) begin
      bus_rd(2'd0, got);
      if (got == exp) break;
      @(negedge clk);
    end
  endtask

  task automatic t_reset;
    logic [31:0] d;
    repeat (12) @(negedge clk);
    bus_rd(2'd0, d); chk("R1 clock-enable reset value", d, IMPL);
    bus_rd(2'd1, d); chk("R1 reset word reset value", d, 32'h0);
    chk("R1 peripheral resets released", {24'h0, prst_n_o}, IMPL);
    chk("R2 gate enables after reset", {24'h0, gate_en_o}, IMPL);
  endtask

  task automatic t_gate_off;
    logic [31:0] d;
    logic seen1;
    bus_wr(2'd0, 32'hBE);
    bus_rd(2'd0, d); chk("R3 readback lags write", d, 32'hBF);
    wait_ce(32'hBE, 20, d); chk("R3 readback reaches written value", d, 32'hBE);
    chk("R2 gate enable low after stop", {31'h0, gate_en_o[0]}, 32'h0);
    seen1 = 1'b0;
    for (int k = 0; k < 16; k++) begin
      #2;
      if (pclk_gated_o[0]) chk("R2 stopped clock stays low", 32'h1, 32'h0);
      seen1 |= pclk_gated_o[1];
    end
    chk("R2 neighbour clock still toggles", {31'h0, seen1}, 32'h1);
  endtask

  task automatic t_block;
    @(negedge clk);
    prdata_i = 32'h1234_5678;
    psel_i = 8'h01; #1;
    chk("R8 select blocked while gated", {24'h0, psel_o}, 32'h0);
    chk("R8 fixed read data while gated", prdata_o, 32'h0);
    psel_i = 8'h02; #1;
    chk("R8 select passes for running peripheral", {24'h0, psel_o}, 32'h2);
    chk("R8 read data passes for running peripheral", prdata_o, 32'h1234_5678);
    psel_i = '0;
  endtask

  task automatic t_reset_gated;
    bit up;
    bus_wr(2'd1, 32'h01);
    chk("R5 reset asserts while clock gated", {31'h0, prst_n_o[0]}, 32'h0);
    bus_wr(2'd1, 32'h00);
    chk("R5 release waits for peripheral clock", {31'h0, prst_n_o[0]}, 32'h0);
    up = 1'b0;
    for (int k = 0; k < 8; k++) begin
      if (prst_n_o[0]) begin up = 1'b1; break; end
      @(negedge clk); #1;
    end
    chk("R5 reset released", {31'h0, up}, 32'h1);
  endtask

  task automatic t_ungate;
    logic [31:0] d;
    bus_wr(2'd0, 32'hBF);
    wait_ce(32'hBF, 20, d); chk("R3 readback after resupply", d, 32'hBF);
    chk("R2 gate enable back on", {31'h0, gate_en_o[0]}, 32'h1);
    psel_i = 8'h01; #1;
    chk("R8 select passes after resupply", {24'h0, psel_o}, 32'h1);
    psel_i = '0;
  endtask

  task automatic t_overlap;
    logic [31:0] d;
    // R8 with R3: select dropped in the cycle the change launches
    @(negedge clk); psel_i = 8'h04;
    bus_wr(2'd0, 32'hBB);
    bus_rd(2'd0, d);
    chk("R3 readback still on during launch", {31'h0, d[2]}, 32'h1);
    chk("R8 select dropped while change in flight", {29'h0, psel_o[2:0]}, 32'h0);
    psel_i = '0;
    wait_ce(32'hBB, 20, d);
    bus_wr(2'd0, 32'hBF);
    wait_ce(32'hBF, 20, d); chk("R2 restore after overlap", d, 32'hBF);
  endtask

  task automatic t_hold;
    logic [31:0] d;
    bit saw0;
    bus_wr(2'd0, 32'hBE);
    bus_wr(2'd0, 32'hBF);
    saw0 = 1'b0;
    for (int k = 0; k < 40; k++) begin
      bus_rd(2'd0, d);
      if (!d[0]) saw0 = 1'b1;
      @(negedge clk);
    end
    bus_rd(2'd0, d);
    chk("R4 first write applied before held one", {31'h0, saw0}, 32'h1);
    chk("R4 held write applied after completion", d, 32'hBF);
    bus_wr(2'd0, 32'hBE);
    bus_wr(2'd0, 32'hBF);
    bus_wr(2'd0, 32'hBE);
    repeat (40) @(negedge clk);
    bus_rd(2'd0, d);
    chk("R4 last held write wins", d, 32'hBE);
    chk("R4 gate follows last write", {31'h0, gate_en_o[0]}, 32'h0);
    bus_wr(2'd0, 32'hBF);
    wait_ce(32'hBF, 20, d);
  endtask

  task automatic t_absent;
    logic [31:0] d;
    bus_wr(2'd0, 32'hFF);
    repeat (20) @(negedge clk);
    bus_rd(2'd0, d); chk("R6 absent clock-enable bit reads 0", d, 32'hBF);
    bus_wr(2'd1, 32'h40);
    bus_rd(2'd1, d); chk("R6 absent reset bit reads 0", d, 32'h0);
    chk("R6 absent peripheral outputs low",
        {30'h0, pclk_gated_o[6], prst_n_o[6]}, 32'h0);
  endtask

  task automatic t_bus_off;
    logic [31:0] d;
    bus_off_i = 8'h20;
    bus_wr(2'd0, 32'h9F);
    bus_wr(2'd1, 32'h20);
    repeat (20) @(negedge clk);
    bus_rd(2'd0, d); chk("R7 clock-enable bit kept while bus off", d, 32'hBF);
    bus_rd(2'd1, d); chk("R7 reset bit kept while bus off", d, 32'h0);
    chk("R7 peripheral reset untouched", {31'h0, prst_n_o[5]}, 32'h1);
    bus_off_i = '0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_gate_off();
    t_block();
    t_reset_gated();
    t_ungate();
    t_overlap();
    t_hold();
    t_absent();
    t_bus_off();
    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    #200000;
    if (!done) begin
      done = 1'b1;
      checks++; errors++;
      $display("FAIL watchdog (R1..R8 run): actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule